// File: doc/BRIEF.md
# PCM Codec Channel Mode and Power Controller

This block decides how one PCM codec channel should run. It watches four board pins: the dual-purpose receive master clock / power-down pin, the dual-purpose receive bit clock / rate-select pin, and the transmit and receive frame sync inputs. It sorts each dual-purpose pin into one of two classes, toggling or held static. From that class and the frame sync activity it derives four results: whether the channel is powered, whether both directions share the transmit master clock, which master-clock divider to use, and whether the transmit PCM output may leave high impedance.

All pins are synchronised into a fast system clock before any decision is made. A pin counts as toggling once it shows two level changes within `STATIC_CYCLES` system clocks. It counts as static once `STATIC_CYCLES` clocks pass with no change. The channel wakes on a frame sync rising edge. It sleeps when the power-down pin sits high. It also sleeps when no frame sync rising edge arrives for `MISS_FRAMES` frame periods of `FRAME_CYCLES` clocks each.

Top module: `codec_chan_mode_ctl`

## Requirements
- R1: After reset, `chan_on`, `mode_shared_clk`, `mode_split_clk`, `sel_hi_rate`, `bit_clk_shared` and `tx_out_permit` are all 0.
- R2: While `rxm_pin` is static high, the channel is powered down (`chan_on`=0), and frame sync pulses do not power it up.
- R3: A rising edge on `tx_frame` or `rx_frame` powers the channel up (`chan_on`=1), unless `rxm_pin` is static high.
- R4: While powered, `mode_shared_clk`=1 when `rxm_pin` is static low. `mode_split_clk`=1 when `rxm_pin` is toggling. A pin is toggling after two level changes within `STATIC_CYCLES` clocks, and static after `STATIC_CYCLES` clocks with no change.
- R5: The channel powers down once `MISS_FRAMES`×`FRAME_CYCLES` clocks pass with no rising edge on either frame sync. Any such edge restarts that count.
- R6: `tx_out_permit` becomes 1 only on the second `tx_frame` rising edge since power-up. The edge that powers the channel up counts as the first. `rx_frame` edges do not count. Power-down clears the permit.
- R7: While powered with the shared clock and `rxb_pin` static, `sel_hi_rate` follows the level of `rxb_pin`: 1 selects the 2.048 MHz divider, and 0 selects the 1.536/1.544 MHz divider. `bit_clk_shared` is 1 in this case.
- R8: In split-clock mode the level of `rxb_pin` is ignored. `sel_hi_rate` keeps its value, and `bit_clk_shared`=0.
- R9: A single level change on a dual-purpose pin does not make that pin count as toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling |
| rst_n | input | 1 | Active-low power-on reset |
| rxm_pin | input | 1 | Receive master clock / power-down pin |
| rxb_pin | input | 1 | Receive bit clock / rate-select pin |
| tx_frame | input | 1 | Transmit frame sync |
| rx_frame | input | 1 | Receive frame sync |
| chan_on | output | 1 | Channel powered; also enables the analog output |
| mode_shared_clk | output | 1 | Transmit master clock drives both directions |
| mode_split_clk | output | 1 | Separate transmit and receive master clocks |
| sel_hi_rate | output | 1 | 1: 2.048 MHz divider, 0: 1.536/1.544 MHz divider |
| bit_clk_shared | output | 1 | Transmit bit clock serves both directions |
| tx_out_permit | output | 1 | Transmit PCM output may be driven |

## Verification
Two events can land in the same clock cycle. One is the power-up decision. The other is the counting of transmit frame sync edges toward the output permit. When a `tx_frame` edge wakes the channel, that same edge must count as the first of the two. The sweep wakes the channel once with each frame sync, for each rate-select level. After one further transmit frame sync, the permit must be open only if the wake-up came from `tx_frame`. The second collision is a frame sync edge arriving while the power-down pin is held high. There the forced power-down must win.

// File: rtl/codec_mode_pkg.sv
package codec_mode_pkg;

    typedef enum logic [1:0] {
        DX_CLOSED = 2'd0,
        DX_ONE    = 2'd1,
        DX_OPEN   = 2'd2
    } dx_stage_t;

    typedef struct packed {
        logic      pwr;
        logic      hi_rate;
        dx_stage_t dx;
    } ctl_state_t;

endpackage

// File: rtl/pin_activity_det.sv
module pin_activity_det #(
    parameter int STATIC_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic active
);
    localparam int CW = $clog2(STATIC_CYCLES + 1);
    localparam logic [CW-1:0] CMAX = CW'(STATIC_CYCLES);

    typedef struct packed {
        logic [2:0]    sh;
        logic [CW-1:0] cnt;
        logic          act;
    } det_state_t;

    det_state_t st_d, st_q;
    logic tgl;

    always_comb begin
        st_d    = st_q;
        tgl     = st_q.sh[1] ^ st_q.sh[2];
        st_d.sh = {st_q.sh[1], st_q.sh[0], pin};
        if (tgl) begin
            st_d.cnt = '0;
            st_d.act = (st_q.cnt != CMAX);
        end else begin
            st_d.cnt = (st_q.cnt == CMAX) ? CMAX : st_q.cnt + 1'b1;
            st_d.act = st_q.act && (st_d.cnt != CMAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= '0;
            st_q.cnt <= CMAX;
            st_q.act <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level  = st_q.sh[1];
    assign active = st_q.act;

    // R4
    act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.act) |-> $past(tgl));

    // R9
    lone_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl && st_q.cnt == CMAX) |=> !st_q.act);

endmodule

// File: rtl/frame_watch.sv
module frame_watch #(
    parameter int FRAME_CYCLES = 1024,
    parameter int MISS_FRAMES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_frame,
    input  logic rx_frame,
    output logic tx_rise,
    output logic rx_rise,
    output logic idle
);
    localparam int FW = $clog2(FRAME_CYCLES);
    localparam int MW = $clog2(MISS_FRAMES + 1);
    localparam logic [FW-1:0] FLAST = FW'(FRAME_CYCLES - 1);
    localparam logic [MW-1:0] MLIM  = MW'(MISS_FRAMES);

    typedef struct packed {
        logic [1:0][2:0] sh;
        logic [FW-1:0]   sub;
        logic [MW-1:0]   miss;
    } fw_state_t;

    fw_state_t st_d, st_q;
    logic [1:0] rise;
    logic [1:0] raw;
    logic       any_rise;

    assign raw = {rx_frame, tx_frame};

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < 2; i++) begin
            rise[i]    = st_q.sh[i][1] & ~st_q.sh[i][2];
            st_d.sh[i] = {st_q.sh[i][1], st_q.sh[i][0], raw[i]};
        end
        any_rise = |rise;
        if (any_rise) begin
            st_d.sub  = '0;
            st_d.miss = '0;
        end else if (st_q.miss != MLIM) begin
            if (st_q.sub == FLAST) begin
                st_d.sub  = '0;
                st_d.miss = st_q.miss + 1'b1;
            end else begin
                st_d.sub = st_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh   <= '0;
            st_q.sub  <= '0;
            st_q.miss <= MLIM;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_rise = rise[0];
    assign rx_rise = rise[1];
    assign idle    = (st_q.miss == MLIM);

    // R5
    quiet_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_rise |=> !idle);

endmodule

// File: rtl/codec_chan_mode_ctl.sv
module codec_chan_mode_ctl
    import codec_mode_pkg::*;
#(
    parameter int STATIC_CYCLES = 64,
    parameter int FRAME_CYCLES  = 1024,
    parameter int MISS_FRAMES   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxm_pin,
    input  logic rxb_pin,
    input  logic tx_frame,
    input  logic rx_frame,
    output logic chan_on,
    output logic mode_shared_clk,
    output logic mode_split_clk,
    output logic sel_hi_rate,
    output logic bit_clk_shared,
    output logic tx_out_permit
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pins, lvl, act;
    logic tx_rise, rx_rise, idle;
    logic forced_off, any_rise, rxb_static;
    ctl_state_t st_d, st_q;

    assign pins = {rxb_pin, rxm_pin};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        pin_activity_det #(.STATIC_CYCLES(STATIC_CYCLES)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (pins[g]),
            .level  (lvl[g]),
            .active (act[g])
        );
    end

    frame_watch #(.FRAME_CYCLES(FRAME_CYCLES), .MISS_FRAMES(MISS_FRAMES)) u_fw (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_frame (tx_frame),
        .rx_frame (rx_frame),
        .tx_rise  (tx_rise),
        .rx_rise  (rx_rise),
        .idle     (idle)
    );

    assign forced_off = ~act[0] & lvl[0];
    assign any_rise   = tx_rise | rx_rise;
    assign rxb_static = ~act[1];

    always_comb begin
        st_d = st_q;
        if (forced_off)    st_d.pwr = 1'b0;
        else if (any_rise) st_d.pwr = 1'b1;
        else if (idle)     st_d.pwr = 1'b0;

        if (st_q.pwr && !act[0] && rxb_static)
            st_d.hi_rate = lvl[1];

        if (!st_d.pwr) begin
            st_d.dx = DX_CLOSED;
        end else if (tx_rise) begin
            case (st_q.dx)
                DX_CLOSED: st_d.dx = DX_ONE;
                default:   st_d.dx = DX_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pwr     <= 1'b0;
            st_q.hi_rate <= 1'b0;
            st_q.dx      <= DX_CLOSED;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_on         = st_q.pwr;
    assign mode_shared_clk = st_q.pwr & ~act[0];
    assign mode_split_clk  = st_q.pwr & act[0];
    assign sel_hi_rate     = st_q.hi_rate;
    assign bit_clk_shared  = st_q.pwr & ~act[0] & rxb_static;
    assign tx_out_permit   = (st_q.dx == DX_OPEN);

    // R2
    forced_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        forced_off |=> !chan_on);

    // R3
    wake_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!forced_off && any_rise) |=> chan_on);

    // R5
    idle_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !any_rise) |=> !chan_on);

    // R6
    permit_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_out_permit) |-> $past(tx_rise));

    // R8
    split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_split_clk |=> $stable(sel_hi_rate));

endmodule

// File: tb/codec_chan_mode_ctl_test.sv
module codec_chan_mode_ctl_test;
    localparam int SC = 16;
    localparam int FC = 32;
    localparam int MF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxm_pin = 1'b0, rxb_pin = 1'b0, tx_frame = 1'b0, rx_frame = 1'b0;
    logic chan_on, mode_shared_clk, mode_split_clk, sel_hi_rate, bit_clk_shared, tx_out_permit;
    int   rxm_mode = 0, rxb_mode = 0;
    int   total = 0, fails = 0;
    logic [7:0] ph = '0;

    always #2 clk = ~clk;

    codec_chan_mode_ctl #(.STATIC_CYCLES(SC), .FRAME_CYCLES(FC), .MISS_FRAMES(MF)) uut (
        .clk(clk), .rst_n(rst_n), .rxm_pin(rxm_pin), .rxb_pin(rxb_pin),
        .tx_frame(tx_frame), .rx_frame(rx_frame), .chan_on(chan_on),
        .mode_shared_clk(mode_shared_clk), .mode_split_clk(mode_split_clk),
        .sel_hi_rate(sel_hi_rate), .bit_clk_shared(bit_clk_shared),
        .tx_out_permit(tx_out_permit)
    );

    initial forever begin
        @(negedge clk);
        ph = ph + 1'b1;
        rxm_pin = (rxm_mode == 2) ? ph[1] : (rxm_mode == 1);
        rxb_pin = (rxb_mode == 2) ? ph[1] : (rxb_mode == 1);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_tx();
        tx_frame = 1'b1; cyc(2); tx_frame = 1'b0;
    endtask

    task automatic pulse_rx();
        rx_frame = 1'b1; cyc(2); rx_frame = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        cyc(5);
        // R1 reset state
        chk("R1 chan_on", chan_on, 0);
        chk("R1 modes", {mode_shared_clk, mode_split_clk}, 0);
        chk("R1 rate/shared", {sel_hi_rate, bit_clk_shared}, 0);
        chk("R1 permit", tx_out_permit, 0);
        rst_n = 1'b1;
        cyc(40);
        chk("R1 stays off without sync", chan_on, 0);

        pulse_rx(); cyc(6);
        chk("R3 wake by rx sync", chan_on, 1);
        chk("R4 shared mode on static low", mode_shared_clk, 1);
        chk("R7 shared bit clock", bit_clk_shared, 1);
        chk("R7 low rate", sel_hi_rate, 0);
        chk("R6 closed after rx wake", tx_out_permit, 0);
        pulse_tx(); cyc(6);
        chk("R6 closed after first tx", tx_out_permit, 0);
        pulse_tx(); cyc(6);
        chk("R6 open after second tx", tx_out_permit, 1);

        rxb_mode = 1; cyc(5);
        chk("R9 single edge stays static", bit_clk_shared, 1);
        cyc(25);
        chk("R7 high rate", sel_hi_rate, 1);
        chk("R9 still static", bit_clk_shared, 1);

        // sweep: wake source x rate level
        for (int src = 0; src < 2; src++) begin
            for (int lv = 0; lv < 2; lv++) begin
                rxm_mode = 1; cyc(30);
                chk("R2 forced off", chan_on, 0);
                chk("R6 cleared by power-down", tx_out_permit, 0);
                pulse_tx(); pulse_rx(); cyc(6);
                chk("R2 sync ignored while forced", chan_on, 0);
                rxb_mode = lv; rxm_mode = 0; cyc(30);
                if (src == 0) pulse_tx(); else pulse_rx();
                cyc(6);
                chk("R3 wake", chan_on, 1);
                chk("R7 rate level", sel_hi_rate, lv);
                chk("R6 closed at wake", tx_out_permit, 0);
                pulse_tx(); cyc(6);
                chk("R6 wake edge counts", tx_out_permit, (src == 0) ? 1 : 0);
                pulse_tx(); cyc(6);
                chk("R6 open", tx_out_permit, 1);
            end
        end

        // split clock mode, rate level ignored
        rxm_mode = 2; cyc(10); pulse_rx(); cyc(30);
        chk("R4 split mode", mode_split_clk, 1);
        chk("R4 not shared", mode_shared_clk, 0);
        chk("R8 bit clock not shared", bit_clk_shared, 0);
        rxb_mode = 0; pulse_rx(); cyc(30);
        chk("R8 rate held", sel_hi_rate, 1);
        chk("R4 toggling keeps power", chan_on, 1);
        rxm_mode = 0; pulse_rx(); cyc(30);
        chk("R4 back to shared", mode_shared_clk, 1);
        chk("R7 rate follows after return", sel_hi_rate, 0);

        // idle timeout, MF*FC = 256 clocks
        pulse_tx(); cyc(238);
        chk("R5 up before timeout", chan_on, 1);
        cyc(40);
        chk("R5 down after timeout", chan_on, 0);
        chk("R6 cleared by timeout", tx_out_permit, 0);
        pulse_rx(); cyc(198);
        pulse_rx(); cyc(198);
        chk("R5 restart keeps power", chan_on, 1);
        cyc(80);
        chk("R5 down after restarted count", chan_on, 0);

        summary();
    end
endmodule